// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the pad settings for an 8-pin general-purpose I/O port and turns them into per-pin controls for the pad cells. It keeps three drive-strength select registers for 2 mA, 4 mA and 8 mA, and four feature registers for open-drain, pull-up, pull-down and slew-rate control. Software reaches these registers through a simple single-cycle register bus. Writes land on a clock edge. Reads are combinational from the read address.

Hardware keeps the drive selection consistent. Every pin always has exactly one drive strength selected. Setting a pin's bit in one drive register clears that pin's bit in the other two. Pull-up and pull-down exclude each other in the same way, but both may be off. The slew-rate setting reaches the pad only while the pin is on 8 mA drive.

The bus carries plain control. A write completes in the cycle its strobe is seen and cannot be back-pressured, so the bus has no valid/ready handshake.

Top module: `pad_cfg_regs`

## Requirements
- R1: After reset, register 0x500 (2 mA) reads 0xFF and every other register reads 0. Every pin's drive code is 2'b00, and the open-drain, pull-up, pull-down and slew outputs are all 0.
- R2: Writing a 1 to bit p of one drive register sets that bit and clears bit p of the other two drive registers. The drive registers sit at 0x500 (2 mA), 0x504 (4 mA) and 0x508 (8 mA). Pin p's drive code sits at drv_code[2p+1:2p]: 2'b00 = 2 mA, 2'b01 = 4 mA, 2'b10 = 8 mA.
- R3: Writing a 0 to a drive-register bit changes nothing. Each pin keeps exactly one drive bit set at all times.
- R4: A drive-register write changes only the pins whose data bit is 1. All other pins keep their settings.
- R5: The open-drain register at 0x50C stores all 8 written bits. Bit p drives od_en[p].
- R6: Pull-up sits at 0x510 and pull-down at 0x514, and a 1 enables the pull. Writing 1 to pin p in one of them clears pin p in the other. Writing 0 clears only that register's bit.
- R7: The slew register at 0x518 stores all 8 written bits. slew_en[p] is high only when slew bit p is set and pin p is on 8 mA drive.
- R8: Reading any of the seven register addresses returns that register in bits 7:0, with the upper bits 0. Any other address reads 0, and a write to it changes nothing.
- R9: A write shows on the read data and on the pad outputs in the cycle after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data, bits 7:0 used |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data for rd_addr |
| drv_code | output | 16 | Per-pin 2-bit drive code |
| od_en | output | 8 | Per-pin open-drain enable |
| pull_up | output | 8 | Per-pin pull-up enable |
| pull_dn | output | 8 | Per-pin pull-down enable |
| slew_en | output | 8 | Per-pin effective slew enable |

## Verification
The hardest case to reach from the ports is a single write that does two things at once. It moves some pins between drive strengths and leaves others alone through zero data bits. It also flips the gated slew outputs in the same cycle. The stimulus first sets the slew register on all pins while only part of the port is on 8 mA. It then writes mixed patterns to the 8 mA and 2 mA registers. Every register is read back after each write, and the pad outputs are compared against a model of the exclusion rules. Zero-data writes and writes to unmapped addresses are placed between these steps. This shows that neither disturbs the state.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  // register slot order within the bank; address = base + 4*slot
  localparam int SLOT_DRV2  = 0;
  localparam int SLOT_DRV4  = 1;
  localparam int SLOT_DRV8  = 2;
  localparam int SLOT_ODRN  = 3;
  localparam int SLOT_PUP   = 4;
  localparam int SLOT_PDN   = 5;
  localparam int SLOT_SLEW  = 6;
  localparam int NUM_SLOTS  = 7;

  localparam int unsigned BANK_BASE = 32'h500;

  typedef enum logic [1:0] {
    DRV_2MA = 2'b00,
    DRV_4MA = 2'b01,
    DRV_8MA = 2'b10
  } drv_code_e;
endpackage

// File: rtl/pad_cfg_addr_dec.sv
module pad_cfg_addr_dec #(
  parameter int ADDR_W = 12,
  parameter int NREG   = 7,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel
);
  for (genvar k = 0; k < NREG; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE + ADDR_W'(4 * k);
    assign sel[k] = (addr == SLOT_ADDR);
  end
endmodule

// File: rtl/pad_cfg_excl_bank.sv
// A group of registers in which each pin may have at most one bit set
// across the group. Setting a bit clears the pin in the sibling registers.
module pad_cfg_excl_bank #(
  parameter int N_PINS     = 8,
  parameter int NREG       = 3,
  parameter int RST_SEL    = 0,  // slot reset to all ones; >= NREG means none
  parameter bit ALLOW_NONE = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NREG-1:0]              wr_sel,
  input  logic [N_PINS-1:0]            wr_bits,
  output logic [NREG-1:0][N_PINS-1:0]  q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++)
        q[k] <= (k == RST_SEL) ? '1 : '0;
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (wr_sel[k]) begin
          for (int p = 0; p < N_PINS; p++) begin
            if (wr_bits[p]) begin
              for (int j = 0; j < NREG; j++)
                q[j][p] <= (j == k);
            end else if (ALLOW_NONE) begin
              q[k][p] <= 1'b0;
            end
          end
        end
      end
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [NREG-1:0] col;
    always_comb
      for (int k = 0; k < NREG; k++) col[k] = q[k][p];

    if (ALLOW_NONE) begin : g_opt
      p_pull_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col) <= 1);
    end else begin : g_req
      p_one_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col) == 1);
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
      p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[k] && wr_bits[p]) |=> (q[k][p] && $countones(col) == 1));
    end
  end

  if (!ALLOW_NONE) begin : g_zero_chk
    p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bits == '0) |=> $stable(q));
  end
endmodule

// File: rtl/pad_cfg_plain_reg.sv
module pad_cfg_plain_reg #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [N_PINS-1:0] wr_bits,
  output logic [N_PINS-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr_sel) q <= wr_bits;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(q));
endmodule

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
  import pad_cfg_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [BUS_W-1:0]      rd_data,
  output logic [2*N_PINS-1:0]   drv_code,
  output logic [N_PINS-1:0]     od_en,
  output logic [N_PINS-1:0]     pull_up,
  output logic [N_PINS-1:0]     pull_dn,
  output logic [N_PINS-1:0]     slew_en
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BANK_BASE);
  localparam int N_DRV  = 3;
  localparam int N_PULL = 2;

  logic [NUM_SLOTS-1:0] wsel_raw, wsel, rsel;
  logic [N_PINS-1:0]    wbits;
  logic                 unused_hi;

  assign wbits     = wr_data[N_PINS-1:0];
  assign unused_hi = ^wr_data[BUS_W-1:N_PINS];

  pad_cfg_addr_dec #(.ADDR_W(ADDR_W), .NREG(NUM_SLOTS), .BASE(BASE)) u_wdec (
    .addr(wr_addr), .sel(wsel_raw));
  pad_cfg_addr_dec #(.ADDR_W(ADDR_W), .NREG(NUM_SLOTS), .BASE(BASE)) u_rdec (
    .addr(rd_addr), .sel(rsel));

  assign wsel = wsel_raw & {NUM_SLOTS{wr_en}};

  logic [N_DRV-1:0][N_PINS-1:0]  drv_q;
  logic [N_PULL-1:0][N_PINS-1:0] pull_q;
  logic [N_PINS-1:0]             od_q, sl_q;

  pad_cfg_excl_bank #(.N_PINS(N_PINS), .NREG(N_DRV), .RST_SEL(0),
                      .ALLOW_NONE(1'b0)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(wsel[SLOT_DRV8:SLOT_DRV2]), .wr_bits(wbits), .q(drv_q));

  pad_cfg_excl_bank #(.N_PINS(N_PINS), .NREG(N_PULL), .RST_SEL(N_PULL),
                      .ALLOW_NONE(1'b1)) u_pull (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(wsel[SLOT_PDN:SLOT_PUP]), .wr_bits(wbits), .q(pull_q));

  pad_cfg_plain_reg #(.N_PINS(N_PINS)) u_od (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_ODRN]), .wr_bits(wbits), .q(od_q));

  pad_cfg_plain_reg #(.N_PINS(N_PINS)) u_slew (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_SLEW]), .wr_bits(wbits), .q(sl_q));

  logic [NUM_SLOTS-1:0][N_PINS-1:0] slot_q;
  assign slot_q[SLOT_DRV2] = drv_q[0];
  assign slot_q[SLOT_DRV4] = drv_q[1];
  assign slot_q[SLOT_DRV8] = drv_q[2];
  assign slot_q[SLOT_ODRN] = od_q;
  assign slot_q[SLOT_PUP]  = pull_q[0];
  assign slot_q[SLOT_PDN]  = pull_q[1];
  assign slot_q[SLOT_SLEW] = sl_q;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (rsel[k]) rd_data[N_PINS-1:0] = slot_q[k];
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pad
    always_comb begin
      if (drv_q[2][p])      drv_code[2*p +: 2] = DRV_8MA;
      else if (drv_q[1][p]) drv_code[2*p +: 2] = DRV_4MA;
      else                  drv_code[2*p +: 2] = DRV_2MA;
    end
    assign slew_en[p] = sl_q[p] & drv_q[2][p];

    p_slew_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slew_en[p] |-> (drv_code[2*p +: 2] == DRV_8MA));
    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      drv_code[2*p +: 2] != 2'b11);
  end

  assign od_en   = od_q;
  assign pull_up = pull_q[0];
  assign pull_dn = pull_q[1];

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel_raw == '0) |=> $stable(slot_q));
endmodule

// File: tb/sim_pad_cfg_regs.sv
module sim_pad_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] drv_code;
  logic [7:0]  od_en, pull_up, pull_dn, slew_en;

  always #5 clk = ~clk;

  pad_cfg_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .drv_code(drv_code),
    .od_en(od_en), .pull_up(pull_up), .pull_dn(pull_dn), .slew_en(slew_en));

  // model of the requirements
  logic [7:0] m2 = 8'hFF, m4 = 8'h00, m8 = 8'h00;
  logic [7:0] mod = 8'h00, mpu = 8'h00, mpd = 8'h00, msl = 8'h00;

  int vectors = 0, fails = 0;
  bit done = 0;

  logic [11:0] qa[$];
  logic [31:0] qrd[$];
  logic [47:0] qpad[$];
  string       qtag[$];

  function automatic logic [31:0] mdl_read(input logic [11:0] a);
    case (a)
      12'h500: return {24'h0, m2};
      12'h504: return {24'h0, m4};
      12'h508: return {24'h0, m8};
      12'h50C: return {24'h0, mod};
      12'h510: return {24'h0, mpu};
      12'h514: return {24'h0, mpd};
      12'h518: return {24'h0, msl};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [47:0] mdl_pads();
    logic [15:0] c;
    for (int p = 0; p < 8; p++)
      c[2*p +: 2] = m8[p] ? 2'b10 : (m4[p] ? 2'b01 : 2'b00);
    return {c, mod, mpu, mpd, msl & m8};
  endfunction

  task automatic mdl_write(input logic [11:0] a, input logic [7:0] d);
    for (int p = 0; p < 8; p++) begin
      case (a)
        12'h500: if (d[p]) begin m2[p] = 1; m4[p] = 0; m8[p] = 0; end
        12'h504: if (d[p]) begin m2[p] = 0; m4[p] = 1; m8[p] = 0; end
        12'h508: if (d[p]) begin m2[p] = 0; m4[p] = 0; m8[p] = 1; end
        12'h510: begin mpu[p] = d[p]; if (d[p]) mpd[p] = 0; end
        12'h514: begin mpd[p] = d[p]; if (d[p]) mpu[p] = 0; end
        default: ;
      endcase
    end
    if (a == 12'h50C) mod = d;
    if (a == 12'h518) msl = d;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    mdl_write(a, d[7:0]);
  endtask

  task automatic chk(input logic [11:0] a, input string tag);
    rd_addr = a;
    qa.push_back(a); qrd.push_back(mdl_read(a));
    qpad.push_back(mdl_pads()); qtag.push_back(tag);
    @(posedge clk); #1;
  endtask

  task automatic chk_all(input string tag);
    for (int k = 0; k < 7; k++) chk(12'h500 + 12'(4 * k), tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (qa.size() > 0) begin
      logic [11:0] a;
      logic [31:0] erd;
      logic [47:0] epad, apad;
      string t;
      a = qa.pop_front(); erd = qrd.pop_front();
      epad = qpad.pop_front(); t = qtag.pop_front();
      apad = {drv_code, od_en, pull_up, pull_dn, slew_en};
      vectors++;
      if (rd_data !== erd || apad !== epad) begin
        fails++;
        $display("FAIL %s addr=%h rd_data=%h exp=%h pads=%h exp=%h",
                 t, a, rd_data, erd, apad, epad);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, vectors=%0d exp=completion", vectors);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_all("R1");
    chk(12'h51C, "R8");

    wr(12'h504, 32'h0000_000F);           // pins 0..3 to 4 mA
    chk_all("R2 R9");
    wr(12'h508, 32'h0000_0003);           // pins 0,1 to 8 mA
    chk_all("R2");
    wr(12'h500, 32'h0000_0000);           // zero write: no effect
    chk_all("R3");
    wr(12'h508, 32'h0000_0000);
    chk_all("R3");
    wr(12'h504, 32'hFFFF_FF80);           // only pin 7, upper bits ignored
    chk_all("R4");

    wr(12'h50C, 32'h0000_00A5);
    chk(12'h50C, "R5");
    wr(12'h50C, 32'h0000_005A);
    chk_all("R5");

    wr(12'h510, 32'h0000_00FF);
    wr(12'h514, 32'h0000_000F);
    chk_all("R6");
    wr(12'h510, 32'h0000_0000);
    chk_all("R6");
    wr(12'h510, 32'h0000_0011);
    chk_all("R6");

    wr(12'h518, 32'h0000_00FF);           // slew armed; only pins 0,1 at 8 mA
    chk(12'h518, "R7");
    wr(12'h508, 32'h0000_00F0);           // move pins 4..7 to 8 mA
    chk_all("R7");
    wr(12'h500, 32'h0000_0021);           // pins 0,5 back to 2 mA
    chk_all("R7 R4");

    wr(12'h520, 32'h0000_00FF);           // unmapped writes
    wr(12'h000, 32'h0000_00FF);
    wr(12'h4FC, 32'h0000_0000);
    chk(12'h520, "R8");
    chk(12'h000, "R8");
    chk_all("R8");

    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    m2 = 8'hFF; m4 = 0; m8 = 0; mod = 0; mpu = 0; mpd = 0; msl = 0;
    chk_all("R1");

    @(posedge clk); #1;
    done = 1;
    summary();
    $finish;
  end
endmodule